// File: doc/BRIEF.md
# Indexed Absolute Read Address Sequencer

This block produces the bus cycles of a read instruction that uses absolute addressing with an 8-bit index added to a 16-bit base. A one-cycle start pulse hands it the current program counter and the index value. The block then steps through a fixed series of read cycles. It fetches the opcode, then the low base byte, then the high base byte. Next it reads the data byte at the indexed address. When the index addition carries into the high byte, the first data read uses a high byte that has not been corrected. The block discards that byte and reads once more from the next page.

When the final read completes, the block raises a one-cycle done pulse. With it come the data byte, the opcode, the base address, the number of bus cycles used (4 or 5) and the program counter advanced by three. Memory is external. Each byte on the data input is sampled at the clock edge that ends the cycle in which its address was driven.

States: `ST_IDLE` (waiting), `ST_OPC` (opcode fetch), `ST_BLO` (base low fetch), `ST_BHI` (base high fetch), `ST_IDX` (read with uncorrected high byte), `ST_FIX` (read from the next page). Transitions:
- `ST_IDLE` → `ST_OPC` on start.
- `ST_OPC` → `ST_BLO` → `ST_BHI` → `ST_IDX`, unconditionally.
- `ST_IDX` → `ST_IDLE` without a carry, or `ST_IDX` → `ST_FIX` with a carry.
- `ST_FIX` → `ST_IDLE`.

Top module: `absx_read_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `done_o`=0, `addr_o`=0x0000.
- R2: A start pulse while idle is followed by three cycles that drive `addr_o` with PC, PC+1 and PC+2 (mod 65536). These cycles capture the opcode, the base low byte and the base high byte, in that order.
- R3: The fourth cycle drives `addr_o` = {base high byte, low 8 bits of (base low byte + X)}.
- R4: When base low + X is below 256, the byte from the fourth cycle is the data, no fifth read is made, and `cycles_o`=4.
- R5: When base low + X is 256 or more, the fourth byte is discarded. A fifth cycle drives {(base high + 1) mod 256, same low byte}, its byte is the data, and `cycles_o`=5.
- R6: `rnw_o` is 1 (read) in every cycle of the sequence.
- R7: `done_o` is high for exactly one cycle, in the cycle after the final read. In that cycle `data_o`, `opcode_o`, `base_o`, `cycles_o` and `pc_next_o` = PC+3 (mod 65536) are valid.
- R8: A start pulse while busy is ignored and does not change the address sequence or results. The block is idle again in the cycle `done_o` is high, and a start in that cycle begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sequence (accepted only when idle) |
| pc_i | input | 16 | Program counter at the opcode |
| x_i | input | 8 | Index value |
| rdata_i | input | 8 | Byte read from memory this cycle |
| addr_o | output | 16 | Address bus |
| rnw_o | output | 1 | Read/write strobe, 1 = read |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 8 | Final data byte |
| opcode_o | output | 8 | Captured opcode |
| base_o | output | 16 | Captured base address |
| cycles_o | output | 3 | Bus cycles used (4 or 5) |
| pc_next_o | output | 16 | PC advanced past the three instruction bytes |

## Verification
The assertions watch the sequence on every cycle. They check that the opcode and base-low addresses are each followed by the next address, and that the next-page read keeps the low byte while incrementing the high byte with wrap. They also check that a cycle with no carry ends at once with a count of 4, that done is a single-cycle pulse seen while idle, and that the captured PC cannot change while busy. The bench scenarios are needed to show the full exact address lists against a behavioural memory, and the correct data byte chosen after a discarded read. They also cover the wrap of page 0xFF to 0x00, the wrap of the PC at the top of memory, and a start accepted in the done cycle.

// File: rtl/absx_pkg.sv
package absx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OPC  = 3'd1,
        ST_BLO  = 3'd2,
        ST_BHI  = 3'd3,
        ST_IDX  = 3'd4,
        ST_FIX  = 3'd5
    } absx_state_e;

    localparam int unsigned CYC_W     = 3;
    localparam int unsigned INSN_LEN  = 3;
endpackage

// File: rtl/absx_fsm.sv
module absx_fsm
    import absx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        carry_i,
    output absx_state_e state_o
);
    absx_state_e state_q;
    absx_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_OPC;
            ST_OPC:  state_d = ST_BLO;
            ST_BLO:  state_d = ST_BHI;
            ST_BHI:  state_d = ST_IDX;
            ST_IDX:  state_d = carry_i ? ST_FIX : ST_IDLE;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/absx_addr_gen.sv
module absx_addr_gen
    import absx_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  absx_state_e   state_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] bal_i,
    input  logic [DW-1:0] bah_i,
    input  logic [DW-1:0] x_i,
    output logic [AW-1:0] addr_o,
    output logic          carry_o
);
    logic [DW:0]   sum;
    logic [DW-1:0] page_fix;

    assign sum      = {1'b0, bal_i} + {1'b0, x_i};
    assign carry_o  = sum[DW];
    assign page_fix = bah_i + DW'(1);

    always_comb begin
        addr_o = '0;
        unique case (state_i)
            ST_IDLE: addr_o = '0;
            ST_OPC:  addr_o = pc_i;
            ST_BLO:  addr_o = pc_i + AW'(1);
            ST_BHI:  addr_o = pc_i + AW'(2);
            ST_IDX:  addr_o = {bah_i, sum[DW-1:0]};
            ST_FIX:  addr_o = {page_fix, sum[DW-1:0]};
            default: addr_o = '0;
        endcase
    end
endmodule

// File: rtl/absx_capture.sv
module absx_capture
    import absx_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  absx_state_e      state_i,
    input  logic             start_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [DW-1:0]    x_i,
    input  logic [DW-1:0]    rdata_i,
    input  logic             carry_i,
    output logic [AW-1:0]    pc_q,
    output logic [DW-1:0]    x_q,
    output logic [DW-1:0]    opcode_q,
    output logic [DW-1:0]    bal_q,
    output logic [DW-1:0]    bah_q,
    output logic [DW-1:0]    data_q,
    output logic             done_q,
    output logic [CYC_W-1:0] cycles_q,
    output logic [AW-1:0]    pc_next_q
);
    localparam logic [CYC_W-1:0] CYC_FAST = CYC_W'(4);
    localparam logic [CYC_W-1:0] CYC_SLOW = CYC_W'(5);

    logic [AW-1:0] pc_adv;
    assign pc_adv = pc_q + AW'(INSN_LEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            x_q       <= '0;
            opcode_q  <= '0;
            bal_q     <= '0;
            bah_q     <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
            cycles_q  <= '0;
            pc_next_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_i)
                ST_IDLE: begin
                    if (start_i) begin
                        pc_q <= pc_i;
                        x_q  <= x_i;
                    end
                end
                ST_OPC: opcode_q <= rdata_i;
                ST_BLO: bal_q    <= rdata_i;
                ST_BHI: bah_q    <= rdata_i;
                ST_IDX: begin
                    if (!carry_i) begin
                        data_q    <= rdata_i;
                        done_q    <= 1'b1;
                        cycles_q  <= CYC_FAST;
                        pc_next_q <= pc_adv;
                    end
                end
                ST_FIX: begin
                    data_q    <= rdata_i;
                    done_q    <= 1'b1;
                    cycles_q  <= CYC_SLOW;
                    pc_next_q <= pc_adv;
                end
                default: done_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/absx_read_seq.sv
module absx_read_seq
    import absx_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [DW-1:0]    x_i,
    input  logic [DW-1:0]    rdata_i,
    output logic [AW-1:0]    addr_o,
    output logic             rnw_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [DW-1:0]    data_o,
    output logic [DW-1:0]    opcode_o,
    output logic [AW-1:0]    base_o,
    output logic [CYC_W-1:0] cycles_o,
    output logic [AW-1:0]    pc_next_o
);
    absx_state_e   state;
    logic          carry;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] x_q;
    logic [DW-1:0] bal_q;
    logic [DW-1:0] bah_q;

    absx_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .carry_i (carry),
        .state_o (state)
    );

    absx_addr_gen #(.AW(AW), .DW(DW)) u_addr (
        .state_i (state),
        .pc_i    (pc_q),
        .bal_i   (bal_q),
        .bah_i   (bah_q),
        .x_i     (x_q),
        .addr_o  (addr_o),
        .carry_o (carry)
    );

    absx_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .start_i   (start_i),
        .pc_i      (pc_i),
        .x_i       (x_i),
        .rdata_i   (rdata_i),
        .carry_i   (carry),
        .pc_q      (pc_q),
        .x_q       (x_q),
        .opcode_q  (opcode_o),
        .bal_q     (bal_q),
        .bah_q     (bah_q),
        .data_q    (data_o),
        .done_q    (done_o),
        .cycles_q  (cycles_o),
        .pc_next_q (pc_next_o)
    );

    assign rnw_o  = 1'b1;
    assign busy_o = (state != ST_IDLE);
    assign base_o = {bah_q, bal_q};
endmodule

// File: rtl/absx_read_seq_chk.sv
module absx_read_seq_chk
    import absx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input absx_state_e      state,
    input logic             carry,
    input logic [15:0]      addr_o,
    input logic [15:0]      pc_q,
    input logic             busy_o,
    input logic             done_o,
    input logic [CYC_W-1:0] cycles_o
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPC || state == ST_BLO) |=> addr_o == $past(addr_o) + 16'd1);

    assert_next_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |-> (addr_o[7:0] == $past(addr_o[7:0])
                               && addr_o[15:8] == $past(addr_o[15:8]) + 8'd1));

    assert_no_carry_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDX && !carry) |=> (done_o && cycles_o == 3'd4 && !busy_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_pc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> pc_q == $past(pc_q));
endmodule

bind absx_read_seq absx_read_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .carry    (carry),
    .addr_o   (addr_o),
    .pc_q     (pc_q),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .cycles_o (cycles_o)
);

// File: tb/tb_absx_read_seq.sv
module tb_absx_read_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  x_i = '0;
    logic [7:0]  rdata_i = '0;
    logic [15:0] addr_o;
    logic        rnw_o, busy_o, done_o;
    logic [7:0]  data_o, opcode_o;
    logic [15:0] base_o, pc_next_o;
    logic [2:0]  cycles_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ovr [int];

    always #2.5 clk = ~clk;

    absx_read_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .x_i(x_i),
        .rdata_i(rdata_i), .addr_o(addr_o), .rnw_o(rnw_o), .busy_o(busy_o),
        .done_o(done_o), .data_o(data_o), .opcode_o(opcode_o), .base_o(base_o),
        .cycles_o(cycles_o), .pc_next_o(pc_next_o)
    );

    function automatic logic [7:0] memrd(input logic [15:0] a);
        if (ovr.exists(int'(a))) return ovr[int'(a)];
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Called at a negative edge; returns at the negative edge where done is expected.
    task automatic run_seq(input logic [15:0] pc, input logic [7:0] bal,
                           input logic [7:0] bah, input logic [7:0] x,
                           input bit inject);
        logic [15:0] exp_a[$];
        logic [8:0]  s;
        logic [15:0] pcx;
        pcx = pc;
        ovr[int'(16'(pc + 16'd1))] = bal;
        ovr[int'(16'(pc + 16'd2))] = bah;
        s = {1'b0, bal} + {1'b0, x};
        exp_a.push_back(pc);
        exp_a.push_back(16'(pc + 16'd1));
        exp_a.push_back(16'(pc + 16'd2));
        exp_a.push_back({bah, s[7:0]});
        if (s[8]) exp_a.push_back({8'(bah + 8'd1), s[7:0]});
        start_i = 1'b1; pc_i = pc; x_i = x;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        foreach (exp_a[i]) begin
            if (i < 3) chk(addr_o == exp_a[i], "R2", "fetch addr", addr_o, exp_a[i]);
            else if (i == 3) chk(addr_o == exp_a[i], "R3", "indexed addr", addr_o, exp_a[i]);
            else chk(addr_o == exp_a[i], "R5", "next-page addr", addr_o, exp_a[i]);
            chk(rnw_o == 1'b1, "R6", "rnw", rnw_o, 1);
            chk(busy_o && !done_o, "R8", "busy/done during seq", {busy_o, done_o}, 2);
            rdata_i = memrd(exp_a[i]);
            if (inject && i == 1) begin
                start_i = 1'b1; pc_i = 16'hDEAD; x_i = 8'h77;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk); @(negedge clk);
        end
        start_i = 1'b0;
        chk(done_o == 1'b1, "R7", "done", done_o, 1);
        chk(busy_o == 1'b0, "R8", "idle at done", busy_o, 0);
        chk(cycles_o == (s[8] ? 3'd5 : 3'd4), s[8] ? "R5" : "R4", "cycles",
            cycles_o, s[8] ? 5 : 4);
        chk(data_o == memrd(exp_a[exp_a.size()-1]), s[8] ? "R5" : "R4", "data",
            data_o, memrd(exp_a[exp_a.size()-1]));
        chk(opcode_o == memrd(pcx), "R2", "opcode", opcode_o, memrd(pcx));
        chk(base_o == {bah, bal}, "R2", "base", base_o, {bah, bal});
        chk(pc_next_o == 16'(pcx + 16'd3), "R7", "pc_next", pc_next_o, 16'(pcx + 16'd3));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        chk(addr_o == 16'h0000, "R1", "addr after reset", addr_o, 0);
        // page cross: reads 0x4512 then 0x4612
        run_seq(16'h0200, 8'h67, 8'h45, 8'hAB, 1'b0);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
        // no page cross
        run_seq(16'h1000, 8'h34, 8'h12, 8'h10, 1'b0);
        // start in done cycle accepted; carry exactly at 0xFF+1
        run_seq(16'h3000, 8'hFF, 8'h20, 8'h01, 1'b0);
        // page 0xFF wraps to 0x00; start while busy ignored
        run_seq(16'h5000, 8'h80, 8'hFF, 8'h90, 1'b1);
        @(negedge clk);
        // zero index, PC wraps at top of memory
        run_seq(16'hFFFE, 8'hF0, 8'h77, 8'h00, 1'b0);
        // maximal no-carry sum 0xFF
        run_seq(16'h0800, 8'h0F, 8'hC0, 8'hF0, 1'b1);
        repeat (2) begin
            @(negedge clk);
            chk(!busy_o && !done_o, "R8", "stays idle", {busy_o, done_o}, 0);
        end
        summary();
    end
endmodule